// File: doc/BRIEF.md
# NAND Flash Bus Controller

This block sits between a host register bus and an 8-bit NAND flash device. The host sets up a configuration word that turns the controller on, drives the flash chip-enable pin, requests a restart of an external ECC accumulator, and sets three strobe timing counts. Each write to the command, address or data location then produces exactly one flash bus cycle of the matching type. Each read of the data location produces one read cycle and returns the byte sampled from the flash.

A bus cycle has three phases: a setup phase with the latch signal held, an active phase with the write or read strobe low, and a hold phase after the strobe has risen. Each phase lasts its programmed count plus one clock. While a cycle is in flight, the host is stalled on further transfer accesses through a ready signal. The flash ready/busy pin can be read back through a status location, and an externally computed ECC value through a result location.

Top module: `nand_bus_ctrl`

## Requirements
- R1: After reset, the configuration reads 0x0000_0800: disabled, chip-enable pin high and all timing fields 0. Both strobes are high and both latch outputs are low.
- R2: The configuration word at offset 0x00 holds the enable at bit 15, the chip-enable level at bit 11, the setup count at bits 9:8, the active-width count at bits 6:4 and the hold count at bits 2:0. All of these read back as written.
- R3: The `fl_ce_n` output always equals configuration bit 11.
- R4: A write to offset 0x04 while enabled runs one cycle with `fl_cle` high through all three phases. The phases last setup+1, width+1 and hold+1 clocks, `fl_we_n` is low only in the active phase, and `fl_dq_out` carries the written byte with `fl_dq_oe` high.
- R5: A write to offset 0x08 while enabled runs the same cycle with `fl_ale` high instead of `fl_cle`.
- R6: A write to offset 0x0C while enabled runs a write cycle with both latch outputs low, the data driven through the hold phase, and `fl_we_n` low in the active phase.
- R7: A read of offset 0x0C while enabled runs a cycle with `fl_re_n` low for width+1 clocks. It keeps `bus_ready` low until the last hold clock. It returns in bits 7:0 the value of `fl_dq_in` at the clock edge where `fl_re_n` rises.
- R8: A transfer access (a write to 0x04, 0x08 or 0x0C, or a read of 0x0C) made while a cycle is running is held with `bus_ready` low until the engine is idle. No other access ever sees `bus_ready` low.
- R9: Bit 0 of offset 0x10 reads the `fl_rdy` input: 1 for ready, 0 for busy.
- R10: Writing 1 to configuration bit 12 gives a one-clock high pulse on `ecc_restart` in the clock after the write. Bit 12 always reads back as 0.
- R11: While disabled, the strobes stay high and the latch outputs stay low. Clearing the enable stops a running cycle. Transfer writes are accepted without effect, and a data read returns 0 without a stall.
- R12: Offset 0x14 reads `ecc_value` in bits 23:0, with the upper bits 0.
- R13: `fl_cle` and `fl_ale` are never high together, and `fl_we_n` and `fl_re_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Host access request, held until `bus_ready` |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W (5) | Byte offset of the location |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid when `bus_ready` is high |
| bus_ready | output | 1 | Access completes on this clock edge |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_re_n | output | 1 | Read strobe, active low |
| fl_dq_out | output | FLASH_W (8) | Byte driven to the flash |
| fl_dq_oe | output | 1 | Output enable for `fl_dq_out` |
| fl_dq_in | input | FLASH_W (8) | Byte from the flash |
| fl_rdy | input | 1 | Flash ready (1) / busy (0) |
| ecc_value | input | ECC_W (24) | Result from the external ECC unit |
| ecc_restart | output | 1 | One-clock ECC restart pulse |

## Verification
Cycles are run with four timing sets: all counts zero, mixed small counts, all counts at maximum, and zero width with a long hold. This separates an off-by-one in each phase counter from a swapped field. The flash data input changes on every clock, so a read that samples one edge early or late returns a different byte from the expected one. Back-to-back command, address and data writes show the stall length. Accesses with the controller disabled, and turning it off in the middle of a cycle, show that nothing reaches the pins.

// File: rtl/nbc_pkg.sv
// Package: shared constants and types for the NAND bus controller.
// Assumes byte offsets on the host bus and an 8-bit flash data path.
package nbc_pkg;

    // Host register offsets (byte addresses)
    localparam int OFS_CFG    = 'h00;
    localparam int OFS_CMD    = 'h04;
    localparam int OFS_ADDR   = 'h08;
    localparam int OFS_DATA   = 'h0C;
    localparam int OFS_STATUS = 'h10;
    localparam int OFS_ECC    = 'h14;

    // Configuration bit positions
    localparam int BIT_EN    = 15;
    localparam int BIT_ECC   = 12;
    localparam int BIT_CE    = 11;
    localparam int SETUP_LSB = 8;
    localparam int WIDTH_LSB = 4;
    localparam int HOLD_LSB  = 0;

    // Timing field widths and shared counter width
    localparam int SETUP_W = 2;
    localparam int WIDTH_W = 3;
    localparam int HOLD_W  = 3;
    localparam int CNT_W   = (SETUP_W > WIDTH_W) ?
                             ((SETUP_W > HOLD_W) ? SETUP_W : HOLD_W) :
                             ((WIDTH_W > HOLD_W) ? WIDTH_W : HOLD_W);

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACTIVE,
        PH_HOLD
    } nbc_phase_e;

    typedef enum logic [1:0] {
        CYC_CMD,
        CYC_ADDR,
        CYC_WDATA,
        CYC_RDATA
    } nbc_cycle_e;

    typedef struct packed {
        logic               en;
        logic               ce_n;
        logic [SETUP_W-1:0] setup;
        logic [WIDTH_W-1:0] width;
        logic [HOLD_W-1:0]  hold;
    } nbc_cfg_t;

endpackage

// File: rtl/nbc_cfg_reg.sv
// Module: configuration register with a self-clearing ECC restart bit.
// Assumes DATA_W > 16; wr_en is a single-cycle qualified write strobe.
module nbc_cfg_reg
    import nbc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output nbc_cfg_t          cfg,
    output logic              ecc_restart,
    output logic [DATA_W-1:0] cfg_rdata
);

    logic unused_wbits;
    assign unused_wbits = ^{wdata[DATA_W-1:BIT_EN+1], wdata[BIT_EN-1:BIT_ECC+1],
                            wdata[BIT_CE-1:SETUP_LSB+SETUP_W],
                            wdata[SETUP_LSB-1:WIDTH_LSB+WIDTH_W],
                            wdata[WIDTH_LSB-1:HOLD_LSB+HOLD_W]};

    // Store the fields on a write; reset to disabled with the chip deselected
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.en    <= 1'b0;
            cfg.ce_n  <= 1'b1;
            cfg.setup <= '0;
            cfg.width <= '0;
            cfg.hold  <= '0;
        end else if (wr_en) begin
            cfg.en    <= wdata[BIT_EN];
            cfg.ce_n  <= wdata[BIT_CE];
            cfg.setup <= wdata[SETUP_LSB +: SETUP_W];
            cfg.width <= wdata[WIDTH_LSB +: WIDTH_W];
            cfg.hold  <= wdata[HOLD_LSB +: HOLD_W];
        end
    end

    // Turn a written restart bit into a single-clock pulse
    always_ff @(posedge clk) begin
        if (!rst_n) ecc_restart <= 1'b0;
        else        ecc_restart <= wr_en && wdata[BIT_ECC];
    end

    // Assemble the readback word; the restart bit always reads 0
    always_comb begin
        cfg_rdata                        = '0;
        cfg_rdata[BIT_EN]                = cfg.en;
        cfg_rdata[BIT_CE]                = cfg.ce_n;
        cfg_rdata[SETUP_LSB +: SETUP_W]  = cfg.setup;
        cfg_rdata[WIDTH_LSB +: WIDTH_W]  = cfg.width;
        cfg_rdata[HOLD_LSB +: HOLD_W]    = cfg.hold;
    end

endmodule

// File: rtl/nbc_strobe_fsm.sv
// Module: three-phase flash bus cycle engine (setup, strobe active, hold).
// Assumes launch is only raised while idle and enabled; a cleared enable
// aborts the cycle at the next edge and gates all pins at once.
module nbc_strobe_fsm
    import nbc_pkg::*;
#(
    parameter int FLASH_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  nbc_cfg_t           cfg,
    input  logic               launch,
    input  nbc_cycle_e         launch_kind,
    input  logic [FLASH_W-1:0] launch_byte,
    input  logic [FLASH_W-1:0] fl_dq_in,
    output logic               busy,
    output logic               last_clk,
    output nbc_cycle_e         kind,
    output logic               fl_cle,
    output logic               fl_ale,
    output logic               fl_we_n,
    output logic               fl_re_n,
    output logic [FLASH_W-1:0] fl_dq_out,
    output logic               fl_dq_oe,
    output logic [FLASH_W-1:0] rd_byte
);

    nbc_phase_e         phase;
    logic [CNT_W-1:0]   cnt;
    logic [FLASH_W-1:0] byte_q;
    logic               in_cycle;
    logic               in_active;

    // Advance through the phases, reloading the counter at each phase entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            kind    <= CYC_CMD;
            byte_q  <= '0;
            rd_byte <= '0;
        end else if (!cfg.en) begin
            phase <= PH_IDLE;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (launch) begin
                        phase  <= PH_SETUP;
                        cnt    <= CNT_W'(cfg.setup);
                        kind   <= launch_kind;
                        byte_q <= launch_byte;
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        phase <= PH_ACTIVE;
                        cnt   <= CNT_W'(cfg.width);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_ACTIVE: begin
                    if (cnt == '0) begin
                        phase <= PH_HOLD;
                        cnt   <= CNT_W'(cfg.hold);
                        if (kind == CYC_RDATA) rd_byte <= fl_dq_in;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (cnt == '0) phase <= PH_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Drive the flash pins from the phase, gated by the enable
    always_comb begin
        in_cycle  = cfg.en && (phase != PH_IDLE);
        in_active = cfg.en && (phase == PH_ACTIVE);
        fl_cle    = in_cycle && (kind == CYC_CMD);
        fl_ale    = in_cycle && (kind == CYC_ADDR);
        fl_we_n   = !(in_active && (kind != CYC_RDATA));
        fl_re_n   = !(in_active && (kind == CYC_RDATA));
        fl_dq_oe  = in_cycle && (kind != CYC_RDATA);
        fl_dq_out = byte_q;
        busy      = (phase != PH_IDLE);
        last_clk  = (phase == PH_HOLD) && (cnt == '0);
    end

endmodule

// File: rtl/nand_bus_ctrl.sv
// Module: top of the NAND flash bus controller: host decode, stall logic
// and readback mux around the configuration register and cycle engine.
// Assumes the host holds bus_sel and its fields stable until bus_ready.
module nand_bus_ctrl
    import nbc_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 32,
    parameter int FLASH_W = 8,
    parameter int ECC_W   = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_ready,
    output logic               fl_ce_n,
    output logic               fl_cle,
    output logic               fl_ale,
    output logic               fl_we_n,
    output logic               fl_re_n,
    output logic [FLASH_W-1:0] fl_dq_out,
    output logic               fl_dq_oe,
    input  logic [FLASH_W-1:0] fl_dq_in,
    input  logic               fl_rdy,
    input  logic [ECC_W-1:0]   ecc_value,
    output logic               ecc_restart
);

    nbc_cfg_t           cfg_q;
    logic [DATA_W-1:0]  cfg_rdata;
    logic               hit_cfg, hit_cmd, hit_addr, hit_data, hit_stat, hit_ecc;
    logic               cfg_wr;
    logic               xfer_req;
    logic               launch;
    nbc_cycle_e         launch_kind;
    logic               busy;
    logic               last_clk;
    nbc_cycle_e         kind;
    logic [FLASH_W-1:0] rd_byte;

    // Decode the offset into location hits
    always_comb begin
        hit_cfg  = (bus_addr == ADDR_W'(OFS_CFG));
        hit_cmd  = (bus_addr == ADDR_W'(OFS_CMD));
        hit_addr = (bus_addr == ADDR_W'(OFS_ADDR));
        hit_data = (bus_addr == ADDR_W'(OFS_DATA));
        hit_stat = (bus_addr == ADDR_W'(OFS_STATUS));
        hit_ecc  = (bus_addr == ADDR_W'(OFS_ECC));
    end

    // Classify the access and decide whether a bus cycle starts now
    always_comb begin
        cfg_wr   = bus_sel && bus_wr && hit_cfg;
        xfer_req = bus_sel && ((bus_wr && (hit_cmd || hit_addr || hit_data)) ||
                               (!bus_wr && hit_data));
        launch   = cfg_q.en && xfer_req && !busy;
        if (hit_cmd)       launch_kind = CYC_CMD;
        else if (hit_addr) launch_kind = CYC_ADDR;
        else if (bus_wr)   launch_kind = CYC_WDATA;
        else               launch_kind = CYC_RDATA;
    end

    // Stall transfers until the engine can take them or the read completes
    always_comb begin
        if (!cfg_q.en || !xfer_req) bus_ready = 1'b1;
        else if (bus_wr)            bus_ready = !busy;
        else                        bus_ready = last_clk && (kind == CYC_RDATA);
    end

    // Select the read data for the addressed location
    always_comb begin
        bus_rdata = '0;
        if (hit_cfg)       bus_rdata = cfg_rdata;
        else if (hit_data) bus_rdata = cfg_q.en ? DATA_W'(rd_byte) : '0;
        else if (hit_stat) bus_rdata = DATA_W'(fl_rdy);
        else if (hit_ecc)  bus_rdata = DATA_W'(ecc_value);
    end

    assign fl_ce_n = cfg_q.ce_n;

    nbc_cfg_reg #(
        .DATA_W (DATA_W)
    ) i_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_wr),
        .wdata       (bus_wdata),
        .cfg         (cfg_q),
        .ecc_restart (ecc_restart),
        .cfg_rdata   (cfg_rdata)
    );

    nbc_strobe_fsm #(
        .FLASH_W (FLASH_W)
    ) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg         (cfg_q),
        .launch      (launch),
        .launch_kind (launch_kind),
        .launch_byte (bus_wdata[FLASH_W-1:0]),
        .fl_dq_in    (fl_dq_in),
        .busy        (busy),
        .last_clk    (last_clk),
        .kind        (kind),
        .fl_cle      (fl_cle),
        .fl_ale      (fl_ale),
        .fl_we_n     (fl_we_n),
        .fl_re_n     (fl_re_n),
        .fl_dq_out   (fl_dq_out),
        .fl_dq_oe    (fl_dq_oe),
        .rd_byte     (rd_byte)
    );

endmodule

// File: rtl/nbc_checker.sv
// Module: protocol assertions for nand_bus_ctrl, attached by bind.
// Assumes en is the stored controller enable inside the top.
module nbc_checker #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wd_ecc,
    input logic              bus_ready,
    input logic              fl_cle,
    input logic              fl_ale,
    input logic              fl_we_n,
    input logic              fl_re_n,
    input logic              fl_dq_oe,
    input logic              ecc_restart
);

    p_quiet_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (fl_we_n && fl_re_n && !fl_cle && !fl_ale));

    p_one_latch_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_cle && fl_ale));

    p_one_strobe_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_we_n && !fl_re_n));

    p_restart_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_restart |-> $past(bus_sel && bus_wr && (bus_addr == ADDR_W'(0)) && wd_ecc));

    p_data_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $rose(fl_we_n)) |-> fl_dq_oe);

    p_stall_scope_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ready |-> (bus_sel && ((bus_addr == ADDR_W'(4)) ||
                        (bus_addr == ADDR_W'(8)) || (bus_addr == ADDR_W'(12)))));

endmodule

bind nand_bus_ctrl nbc_checker #(
    .ADDR_W (ADDR_W)
) i_nbc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (cfg_q.en),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .wd_ecc      (bus_wdata[12]),
    .bus_ready   (bus_ready),
    .fl_cle      (fl_cle),
    .fl_ale      (fl_ale),
    .fl_we_n     (fl_we_n),
    .fl_re_n     (fl_re_n),
    .fl_dq_oe    (fl_dq_oe),
    .ecc_restart (ecc_restart)
);

// File: tb/test_nand_bus_ctrl.sv
`timescale 1ns/1ps
// Bench: behavioural per-clock reference model plus directed checks.
module test_nand_bus_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        fl_ce_n, fl_cle, fl_ale, fl_we_n, fl_re_n, fl_dq_oe, ecc_restart;
    logic [7:0]  fl_dq_out;
    logic [7:0]  fl_dq_in;
    logic        fl_rdy = 1'b1;
    logic [23:0] ecc_value = 24'h3C96E1;

    int    n_checks = 0;
    int    n_fails  = 0;
    int    cyc      = 0;
    string cur_req  = "R1";
    bit    model_on = 1'b0;

    always #2.5 clk = ~clk;
    always @(negedge clk) cyc <= cyc + 1;
    assign fl_dq_in = 8'(cyc) ^ 8'h5A;

    nand_bus_ctrl i_nand_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .fl_ce_n(fl_ce_n), .fl_cle(fl_cle), .fl_ale(fl_ale),
        .fl_we_n(fl_we_n), .fl_re_n(fl_re_n), .fl_dq_out(fl_dq_out),
        .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in), .fl_rdy(fl_rdy),
        .ecc_value(ecc_value), .ecc_restart(ecc_restart)
    );

    // Reference model state
    bit m_en, m_ce, m_busy, m_ecc;
    int m_s, m_w, m_h, m_t, m_S, m_W, m_H, m_kind, m_byte, m_rd;

    function automatic bit is_xfer();
        return bus_sel && ((bus_wr && (bus_addr == 4 || bus_addr == 8 || bus_addr == 12)) ||
                           (!bus_wr && bus_addr == 12));
    endfunction

    // Model update on each clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en <= 0; m_ce <= 1; m_s <= 0; m_w <= 0; m_h <= 0;
            m_busy <= 0; m_t <= 0; m_kind <= 0; m_byte <= 0; m_rd <= 0; m_ecc <= 0;
            m_S <= 1; m_W <= 1; m_H <= 1;
        end else begin
            m_ecc <= bus_sel && bus_wr && bus_addr == 0 && bus_wdata[12];
            if (bus_sel && bus_wr && bus_addr == 0) begin
                m_en <= bus_wdata[15]; m_ce <= bus_wdata[11];
                m_s <= int'(bus_wdata[9:8]); m_w <= int'(bus_wdata[6:4]);
                m_h <= int'(bus_wdata[2:0]);
            end
            if (!m_en) m_busy <= 0;
            else if (m_busy) begin
                if (m_kind == 3 && m_t == m_S + m_W - 1) m_rd <= int'(fl_dq_in);
                if (m_t == m_S + m_W + m_H - 1) m_busy <= 0;
                else m_t <= m_t + 1;
            end else if (is_xfer()) begin
                m_busy <= 1; m_t <= 0;
                m_S <= m_s + 1; m_W <= m_w + 1; m_H <= m_h + 1;
                m_kind <= (bus_addr == 4) ? 0 : (bus_addr == 8) ? 1 : bus_wr ? 2 : 3;
                m_byte <= int'(bus_wdata[7:0]);
            end
        end
    end

    // Compare every output with the model once per clock
    always @(negedge clk) begin
        #1;
        if (model_on) begin
            bit act, in_act, e_rdy;
            logic [7:0] e_pins, a_pins;
            logic [31:0] e_rd;
            bit bad;
            act    = m_en && m_busy;
            in_act = act && m_t >= m_S && m_t < m_S + m_W;
            if (!m_en || !is_xfer()) e_rdy = 1;
            else if (bus_wr) e_rdy = !m_busy;
            else e_rdy = m_busy && m_kind == 3 && m_t == m_S + m_W + m_H - 1;
            e_pins = {m_ce, act && m_kind == 0, act && m_kind == 1,
                      !(in_act && m_kind != 3), !(in_act && m_kind == 3),
                      act && m_kind != 3, m_ecc, e_rdy};
            a_pins = {fl_ce_n, fl_cle, fl_ale, fl_we_n, fl_re_n, fl_dq_oe, ecc_restart, bus_ready};
            bad = (e_pins !== a_pins);
            if (act && m_kind != 3 && fl_dq_out !== 8'(m_byte)) bad = 1;
            e_rd = 0;
            if (bus_sel && !bus_wr && e_rdy) begin
                case (int'(bus_addr))
                    0:  e_rd = (32'(m_en) << 15) | (32'(m_ce) << 11) | (32'(m_s) << 8) |
                               (32'(m_w) << 4) | 32'(m_h);
                    12: e_rd = m_en ? 32'(m_rd) : 0;
                    16: e_rd = 32'(fl_rdy);
                    20: e_rd = 32'(ecc_value);
                    default: e_rd = 0;
                endcase
                if (bus_rdata !== e_rd) bad = 1;
            end
            n_checks++;
            if (bad) begin
                n_fails++;
                $display("FAIL %s cycle %0d pins act=%b exp=%b dq act=%h exp=%h rdata act=%h exp=%h",
                         cur_req, cyc, a_pins, e_pins, fl_dq_out, 8'(m_byte), bus_rdata, e_rd);
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One host access; called at a falling edge, returns at a falling edge
    task automatic host(input bit wr, input int addr, input logic [31:0] wd,
                        output logic [31:0] rd, output int ncyc, output int c_req);
        bus_sel = 1; bus_wr = wr; bus_addr = 5'(addr); bus_wdata = wd;
        ncyc = 0; c_req = 0;
        forever begin
            #1;
            if (ncyc == 0) c_req = cyc;
            ncyc++;
            if (bus_ready) begin
                rd = bus_rdata;
                @(posedge clk);
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) begin
        if (cyc > 40000) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int nc, cr, L;
        idle(4);
        rst_n = 1;
        model_on = 1;
        idle(1);

        cur_req = "R1";
        host(0, 'h00, 0, rd, nc, cr);
        check("R1 cfg reset", rd, 32'h0000_0800);
        check("R1 pins idle", {fl_ce_n, fl_cle, fl_ale, fl_we_n, fl_re_n}, 32'b10011);

        cur_req = "R11";
        host(1, 'h04, 32'h90, rd, nc, cr);
        check("R11 write accepted at once", nc, 1);
        idle(10);
        check("R11 no strobe", {fl_cle, fl_we_n}, 32'b01);
        host(0, 'h0C, 0, rd, nc, cr);
        check("R11 read returns 0", rd, 0);
        check("R11 read no stall", nc, 1);

        cur_req = "R9";
        fl_rdy = 0;
        host(0, 'h10, 0, rd, nc, cr);
        check("R9 busy", rd, 0);
        fl_rdy = 1;
        host(0, 'h10, 0, rd, nc, cr);
        check("R9 ready", rd, 1);

        cur_req = "R12";
        host(0, 'h14, 0, rd, nc, cr);
        check("R12 ecc value", rd, 32'h003C96E1);

        cur_req = "R2";
        host(1, 'h00, 32'h0000_8000, rd, nc, cr);
        host(0, 'h00, 0, rd, nc, cr);
        check("R2 readback", rd, 32'h0000_8000);
        check("R3 ce low", fl_ce_n, 0);

        for (int k = 0; k < 4; k++) begin
            int s, w, h;
            s = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 3 : 2;
            w = (k == 0) ? 0 : (k == 1) ? 2 : (k == 2) ? 7 : 0;
            h = (k == 0) ? 0 : (k == 1) ? 3 : (k == 2) ? 7 : 5;
            L = s + w + h + 3;
            cur_req = "R2";
            host(1, 'h00, 32'h8000 | (s << 8) | (w << 4) | h, rd, nc, cr);
            host(0, 'h00, 0, rd, nc, cr);
            check("R2 timing readback", rd, 32'h8000 | (s << 8) | (w << 4) | h);
            cur_req = "R4";
            host(1, 'h04, 32'h70 + k, rd, nc, cr);
            check("R4 command accepted", nc, 1);
            cur_req = "R5";
            host(1, 'h08, 32'hA0 + k, rd, nc, cr);
            check("R8 address stalled", nc, L + 1);
            cur_req = "R6";
            host(1, 'h0C, 32'hC3 ^ k, rd, nc, cr);
            check("R8 data write stalled", nc, L + 1);
            idle(L + 2);
            cur_req = "R7";
            host(0, 'h0C, 0, rd, nc, cr);
            check("R7 read stall length", nc, L + 1);
            check("R7 read byte", rd, 32'(8'(cr + s + w + 2) ^ 8'h5A));
        end

        cur_req = "R10";
        host(1, 'h00, 32'h0000_9000, rd, nc, cr);
        #1;
        check("R10 pulse high", ecc_restart, 1);
        @(negedge clk); #1;
        check("R10 pulse ends", ecc_restart, 0);
        host(0, 'h00, 0, rd, nc, cr);
        check("R10 bit reads 0", rd, 32'h0000_8000);

        cur_req = "R3";
        host(1, 'h00, 32'h0000_8800, rd, nc, cr);
        check("R3 ce high", fl_ce_n, 1);

        cur_req = "R11";
        host(1, 'h00, 32'h0000_8377, rd, nc, cr);
        host(1, 'h04, 32'h55, rd, nc, cr);
        idle(5);
        host(1, 'h00, 32'h0000_0377, rd, nc, cr);
        #1;
        check("R11 abort latch low", {fl_cle, fl_we_n}, 32'b01);
        idle(25);
        check("R11 stays quiet", {fl_cle, fl_ale, fl_we_n, fl_re_n}, 32'b0011);

        idle(3);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule